// File: doc/BRIEF.md
# Token-Ring FIFO Cascade Controller

This block is the per-device control that lets several FIFO devices act as one deeper FIFO. The devices are wired in a closed ring: each device's read token output feeds the read token input of the next one, and the last device feeds the first. A separate write ring runs alongside with the same wiring. Only the device that holds the read token may read, and only the device that holds the write token may write. When the holder performs its operation on the last physical location of its own memory, it passes the token on with a one-cycle low pulse and gives up ownership.

The role of each device is latched while reset is held. It is taken from the first-load pin and from the write token input, which doubles as a configuration pin during reset. A standalone device ignores the rings entirely, grants every enabled operation and never pulses. The block also produces the storage address for each side and the output-enable gate of the read data bus, which is closed whenever the device does not own reading.

Top module: `casc_ring_ctrl`

## Requirements
- R1: While `rst_n` is low each clock domain decodes its role from `fl_n` and `wr_xi_n`: `fl_n`=0 and `wr_xi_n`=0 gives standalone, `fl_n`=0 and `wr_xi_n`=1 gives ring master, `fl_n`=1 gives ring slave. The role stays fixed after reset is released, whatever those pins do later.
- R2: Directly after reset a master owns both the read and the write token, and a slave owns neither.
- R3: `rd_grant` equals `rd_en` while the device owns reading and is 0 otherwise; `wr_grant` behaves the same for writing. Without a grant the matching address does not move.
- R4: Each granted operation advances the matching address by one on the clock edge; a grant at address DEPTH-1 takes it back to 0. Both addresses are 0 after reset.
- R5: In a ring role, a grant at address DEPTH-1 drives the matching token output (`rd_xo_n` or `wr_xo_n`) low for exactly the following clock cycle and removes ownership from that cycle on.
- R6: A device in a ring role that sees its token input low at a rising edge of the matching clock owns that side from the next cycle on.
- R7: `dq_oe` equals `oe` while the device owns reading (always in standalone) and is 0 otherwise.
- R8: In standalone every enabled operation is granted, both token outputs stay high, and the token inputs have no effect.
- R9: Both token outputs are high while reset is held.
- R10: The read and write sides are independent: operations on one side leave the other side's grant, address and token output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_clk | input | 1 | Read side clock |
| wr_clk | input | 1 | Write side clock |
| rst_n | input | 1 | Active-low reset, sampled on each clock |
| fl_n | input | 1 | First-load pin, low selects master or standalone |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| rd_xi_n | input | 1 | Read token input from previous device |
| wr_xi_n | input | 1 | Write token input; role pin during reset |
| oe | input | 1 | Output enable request for the read data bus |
| rd_grant | output | 1 | Read performed this cycle |
| wr_grant | output | 1 | Write performed this cycle |
| rd_addr | output | $clog2(DEPTH) | Next read location |
| wr_addr | output | $clog2(DEPTH) | Next write location |
| rd_xo_n | output | 1 | Read token pulse to next device |
| wr_xo_n | output | 1 | Write token pulse to next device |
| dq_oe | output | 1 | Read data bus drive enable |

## Verification
Grants and the output enable are combinational on the current ownership, so they are due in the same cycle as the request; addresses and token pulses move on the edge that takes the grant and are seen one cycle later; a received token yields grants one cycle after the pulse, leaving one idle cycle per hand-over. The bench drives inputs at the falling edge and samples just after it, so every sample shows the state left by the previous rising edge, and it walks a two-device ring cycle by cycle against an owner schedule computed from DEPTH alone.

// File: rtl/casc_pkg.sv
package casc_pkg;

   typedef enum logic [1:0] {
      CM_SOLO   = 2'd0,
      CM_LEAD   = 2'd1,
      CM_FOLLOW = 2'd2
   } casc_mode_e;

   function automatic casc_mode_e casc_decode(input logic fl_n, input logic cfg_n);
      if (fl_n)
         return CM_FOLLOW;
      else if (cfg_n)
         return CM_LEAD;
      else
         return CM_SOLO;
   endfunction

endpackage

// File: rtl/casc_mode_latch.sv
module casc_mode_latch
   import casc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fl_n,
   input  logic       cfg_n,
   output casc_mode_e mode_d,
   output casc_mode_e mode_q
);

   assign mode_d = casc_decode(fl_n, cfg_n);

   // role follows the pins only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= mode_d;
   end

endmodule

// File: rtl/casc_loc_ptr.sv
module casc_loc_ptr #(
   parameter int DEPTH = 2048,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [PTR_W-1:0] loc,
   output logic             at_last
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("casc_loc_ptr: DEPTH must be at least 2");
      end
   endgenerate

   assign at_last = (loc == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)
         loc <= '0;
      else if (step)
         loc <= at_last ? '0 : loc + 1'b1;
   end

endmodule

// File: rtl/casc_token_lane.sv
module casc_token_lane
   import casc_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fl_n,
   input  logic             cfg_n,
   input  logic             op_en,
   input  logic             xi_n,
   output logic             grant,
   output logic             xo_n,
   output logic             own,
   output logic [PTR_W-1:0] addr,
   output casc_mode_e       mode
);

   casc_mode_e mode_d;
   logic       at_last;
   logic       tok_q;
   logic       solo;

   casc_mode_latch u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .fl_n   (fl_n),
      .cfg_n  (cfg_n),
      .mode_d (mode_d),
      .mode_q (mode)
   );

   casc_loc_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (grant),
      .loc     (addr),
      .at_last (at_last)
   );

   assign solo  = (mode == CM_SOLO);
   assign own   = solo | tok_q;
   assign grant = op_en & own;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tok_q <= (mode_d == CM_LEAD);
         xo_n  <= 1'b1;
      end else begin
         xo_n <= 1'b1;
         if (!solo) begin
            if (grant && at_last) begin
               tok_q <= 1'b0;
               xo_n  <= 1'b0;
            end else if (!xi_n) begin
               tok_q <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/casc_ring_ctrl.sv
module casc_ring_ctrl
   import casc_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int NSIDE = 2
) (
   input  logic             rd_clk,
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             fl_n,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic             rd_xi_n,
   input  logic             wr_xi_n,
   input  logic             oe,
   output logic             rd_grant,
   output logic             wr_grant,
   output logic [PTR_W-1:0] rd_addr,
   output logic [PTR_W-1:0] wr_addr,
   output logic             rd_xo_n,
   output logic             wr_xo_n,
   output logic             dq_oe
);

   // side 0 = write, side 1 = read
   localparam int SW = 0;
   localparam int SR = 1;

   logic [NSIDE-1:0] clk_v;
   logic [NSIDE-1:0] en_v;
   logic [NSIDE-1:0] xi_v;
   logic [NSIDE-1:0] grant_v;
   logic [NSIDE-1:0] xo_v;
   logic [NSIDE-1:0] own_v;
   logic [PTR_W-1:0] addr_v [NSIDE];
   casc_mode_e       mode_v [NSIDE];

   assign clk_v[SW] = wr_clk;
   assign clk_v[SR] = rd_clk;
   assign en_v[SW]  = wr_en;
   assign en_v[SR]  = rd_en;
   assign xi_v[SW]  = wr_xi_n;
   assign xi_v[SR]  = rd_xi_n;

   generate
      for (genvar g = 0; g < NSIDE; g++) begin : g_side
         casc_token_lane #(.DEPTH(DEPTH)) u_lane (
            .clk   (clk_v[g]),
            .rst_n (rst_n),
            .fl_n  (fl_n),
            .cfg_n (wr_xi_n),
            .op_en (en_v[g]),
            .xi_n  (xi_v[g]),
            .grant (grant_v[g]),
            .xo_n  (xo_v[g]),
            .own   (own_v[g]),
            .addr  (addr_v[g]),
            .mode  (mode_v[g])
         );
      end
   endgenerate

   assign wr_grant = grant_v[SW];
   assign rd_grant = grant_v[SR];
   assign wr_addr  = addr_v[SW];
   assign rd_addr  = addr_v[SR];
   assign wr_xo_n  = xo_v[SW];
   assign rd_xo_n  = xo_v[SR];
   assign dq_oe    = oe & own_v[SR];

endmodule

// File: rtl/casc_ring_ctrl_chk.sv
module casc_ring_ctrl_chk
   import casc_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic             rd_clk,
   input logic             wr_clk,
   input logic             rst_n,
   input logic             rd_grant,
   input logic             wr_grant,
   input logic [PTR_W-1:0] rd_addr,
   input logic [PTR_W-1:0] wr_addr,
   input logic             rd_xo_n,
   input logic             wr_xo_n,
   input logic             dq_oe,
   input logic             rd_own,
   input logic             wr_own,
   input casc_mode_e       rd_mode,
   input casc_mode_e       wr_mode
);

   p_mode_hold_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(rd_mode));

   p_addr_hold_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(rd_grant)) |-> $stable(rd_addr));

   p_wr_addr_hold_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_grant)) |-> $stable(wr_addr));

   p_wrap_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(rd_xo_n) |-> (rd_addr == '0));

   p_pulse_width_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_xo_n |=> rd_xo_n);

   p_wr_pulse_width_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !wr_xo_n |=> wr_xo_n);

   p_release_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(rd_xo_n) |-> !rd_own);

   p_wr_release_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $fell(wr_xo_n) |-> (!wr_own && !wr_grant));

   p_bus_release_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(rd_xo_n) |-> !dq_oe);

   p_solo_quiet_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_mode == CM_SOLO) |-> rd_xo_n);

   p_wr_solo_quiet_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_mode == CM_SOLO) |-> wr_xo_n);

endmodule

bind casc_ring_ctrl casc_ring_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
   .rd_clk   (rd_clk),
   .wr_clk   (wr_clk),
   .rst_n    (rst_n),
   .rd_grant (rd_grant),
   .wr_grant (wr_grant),
   .rd_addr  (rd_addr),
   .wr_addr  (wr_addr),
   .rd_xo_n  (rd_xo_n),
   .wr_xo_n  (wr_xo_n),
   .dq_oe    (dq_oe),
   .rd_own   (own_v[1]),
   .wr_own   (own_v[0]),
   .rd_mode  (mode_v[1]),
   .wr_mode  (mode_v[0])
);

// File: tb/casc_ring_ctrl_tb.sv
module casc_ring_ctrl_tb;

   localparam int D  = 4;
   localparam int AW = $clog2(D);
   localparam int P  = 2 * (D + 1);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic sa_tie = 1'b0, sa_wr_pin = 1'b0, xi_force = 1'b1;
   logic m_rd_en = 0, m_wr_en = 0, s_rd_en = 0, s_wr_en = 0;
   logic m_oe = 1'b1, s_oe = 1'b1;

   logic m_rd_grant, m_wr_grant, m_rd_xo_n, m_wr_xo_n, m_dq_oe;
   logic s_rd_grant, s_wr_grant, s_rd_xo_n, s_wr_xo_n, s_dq_oe;
   logic [AW-1:0] m_rd_addr, m_wr_addr, s_rd_addr, s_wr_addr;
   logic m_rd_xi, m_wr_xi;

   assign m_rd_xi = sa_tie ? xi_force  : s_rd_xo_n;
   assign m_wr_xi = sa_tie ? sa_wr_pin : s_wr_xo_n;

   casc_ring_ctrl #(.DEPTH(D)) u_dut (
      .rd_clk(clk), .wr_clk(clk), .rst_n(rst_n), .fl_n(1'b0),
      .rd_en(m_rd_en), .wr_en(m_wr_en), .rd_xi_n(m_rd_xi), .wr_xi_n(m_wr_xi),
      .oe(m_oe), .rd_grant(m_rd_grant), .wr_grant(m_wr_grant),
      .rd_addr(m_rd_addr), .wr_addr(m_wr_addr),
      .rd_xo_n(m_rd_xo_n), .wr_xo_n(m_wr_xo_n), .dq_oe(m_dq_oe)
   );

   casc_ring_ctrl #(.DEPTH(D)) u_slv (
      .rd_clk(clk), .wr_clk(clk), .rst_n(rst_n), .fl_n(1'b1),
      .rd_en(s_rd_en), .wr_en(s_wr_en), .rd_xi_n(m_rd_xo_n), .wr_xi_n(m_wr_xo_n),
      .oe(s_oe), .rd_grant(s_rd_grant), .wr_grant(s_wr_grant),
      .rd_addr(s_rd_addr), .wr_addr(s_wr_addr),
      .rd_xo_n(s_rd_xo_n), .wr_xo_n(s_wr_xo_n), .dq_oe(s_dq_oe)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic sa);
      sa_tie = sa; sa_wr_pin = 1'b0; xi_force = 1'b1;
      m_oe = 1'b1; s_oe = 1'b1;
      m_rd_en = 1; m_wr_en = 1; s_rd_en = 1; s_wr_en = 1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R9: token outputs idle high during reset even with requests active
      chk("R9 token outputs in reset", {m_rd_xo_n, m_wr_xo_n, s_rd_xo_n, s_wr_xo_n}, 4'b1111);
      @(negedge clk);
      rst_n = 1'b1;
      m_rd_en = 0; m_wr_en = 0; s_rd_en = 0; s_wr_en = 0;
   endtask

   // one full revolution of a token on the chosen side, plus the return to the master
   task automatic ring_walk(input bit rd_side);
      do_reset(1'b0);
      if (rd_side) begin m_rd_en = 1; s_rd_en = 1; end
      else begin m_wr_en = 1; s_wr_en = 1; end
      for (int t = 0; t <= P; t++) begin
         int seg, e_mg, e_sg, e_mxo, e_sxo, e_ma, e_sa;
         if (t > 0) @(negedge clk);
         #1;
         seg   = t % P;
         e_mg  = (seg < D) ? 1 : 0;
         e_sg  = (seg > D && seg <= 2 * D) ? 1 : 0;
         e_mxo = (seg == D) ? 0 : 1;
         e_sxo = (seg == 2 * D + 1) ? 0 : 1;
         e_ma  = (seg < D) ? seg : 0;
         e_sa  = (e_sg == 1) ? seg - D - 1 : 0;
         if (rd_side) begin
            chk("R2/R3/R6 read grants m,s", {m_rd_grant, s_rd_grant}, {e_mg[0], e_sg[0]});
            chk("R5 read token pulses m,s", {m_rd_xo_n, s_rd_xo_n}, {e_mxo[0], e_sxo[0]});
            chk("R4 master read addr", m_rd_addr, e_ma);
            chk("R4 slave read addr", s_rd_addr, e_sa);
            chk("R7 bus enable m,s", {m_dq_oe, s_dq_oe}, {e_mg[0], e_sg[0]});
            chk("R10 write side idle", {m_wr_grant, s_wr_grant, m_wr_xo_n, s_wr_xo_n, m_wr_addr, s_wr_addr},
                {4'b0011, {AW{1'b0}}, {AW{1'b0}}});
         end else begin
            chk("R2/R3/R6 write grants m,s", {m_wr_grant, s_wr_grant}, {e_mg[0], e_sg[0]});
            chk("R5 write token pulses m,s", {m_wr_xo_n, s_wr_xo_n}, {e_mxo[0], e_sxo[0]});
            chk("R4 master write addr", m_wr_addr, e_ma);
            chk("R4 slave write addr", s_wr_addr, e_sa);
            chk("R10 read side idle", {m_rd_grant, s_rd_grant, m_rd_xo_n, s_rd_xo_n, m_rd_addr, s_rd_addr},
                {4'b0011, {AW{1'b0}}, {AW{1'b0}}});
            chk("R2 master keeps read bus", {m_dq_oe, s_dq_oe}, 2'b10);
         end
      end
   endtask

   // read requests with gaps: only enabled cycles move the address
   task automatic gapped_reads();
      logic [5:0] pat;
      int ea [6];
      pat = 6'b101101;
      ea  = '{0, 1, 1, 2, 3, 3};
      do_reset(1'b0);
      s_rd_en = 1;
      for (int t = 0; t < 6; t++) begin
         if (t > 0) @(negedge clk);
         m_rd_en = pat[t];
         #1;
         chk("R3 gapped read grant", m_rd_grant, pat[t]);
         chk("R3 gapped read addr", m_rd_addr, ea[t]);
         chk("R3 slave without token", s_rd_grant, 0);
      end
      @(negedge clk);
      m_rd_en = 1;
      #1;
      chk("R5 pulse after last location", {m_rd_xo_n, m_rd_grant, s_rd_grant}, 3'b000);
      chk("R4 wrap after gapped reads", m_rd_addr, 0);
      @(negedge clk);
      #1;
      chk("R6 slave takes over", {s_rd_grant, m_rd_grant, m_rd_xo_n}, 3'b101);
      chk("R7 bus moves to slave", {m_dq_oe, s_dq_oe}, 2'b01);
      s_oe = 1'b0;
      #1;
      chk("R7 oe low closes owner bus", s_dq_oe, 0);
   endtask

   task automatic standalone();
      do_reset(1'b1);
      sa_wr_pin = 1'b1;  // R1: later pin level must not change the role
      m_rd_en = 1;
      for (int t = 0; t < 6; t++) begin
         if (t > 0) @(negedge clk);
         xi_force = t[0];
         #1;
         chk("R8 standalone grant", m_rd_grant, 1);
         chk("R8 standalone read addr", m_rd_addr, t % D);
         chk("R8 standalone outputs high", {m_rd_xo_n, m_wr_xo_n}, 2'b11);
         chk("R7 standalone bus", m_dq_oe, 1);
      end
      @(negedge clk);
      m_oe = 1'b0; m_wr_en = 1;
      #1;
      chk("R7 standalone oe low", m_dq_oe, 0);
      chk("R1 role kept after reset", {m_rd_grant, m_wr_grant}, 2'b11);
      chk("R10 write addr untouched by reads", m_wr_addr, 0);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      ring_walk(1'b1);
      ring_walk(1'b0);
      gapped_reads();
      standalone();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule